// File: doc/BRIEF.md
# Serial Crosspoint Configuration Port

This block is the control side of a 32-input, 16-output routing matrix. A host loads a fixed-length configuration word one bit at a time on a serial clock while chip select is low. The far end of the shift register is driven out on a serial output, so several ports can be chained. Each port in the chain then holds its own word after one long shift. A second rank then makes the shifted word live. It is a level-sensitive latch, opened while the update strobe is low.

From the live word the block decodes the following:
- a one-hot route select over the 32 inputs for each output;
- an enable for each output;
- one global clamp enable;
- a flag that is raised when the padding field of the word is not all zeros.

An asynchronous active-low reset clears the shift register and the live word, so that every output comes up disabled.

Top module: `xpt_cfg_port`

## Requirements
- R1: A frame is exactly 193 bits long. One bit is taken from `sdi` at each rising `clk` edge while `cs_n` is low. After 193 such edges the first bit of the frame is presented at `sdo`, and one more edge presents the second bit.
- R2: A bit entered at `sdi` reaches `sdo` 193 shifts later. In a chain where `sdo` feeds the next port's `sdi`, the frame for the farthest port is sent first. After 386 shifts, a two-port chain holds one frame in each port.
- R3: While `cs_n` is high, neither the shift register (seen at `sdo`) nor the live configuration changes, whatever `sdi`, `clk` and `update_n` do.
- R4: The stream order is fixed. Stream position 0 is the clamp enable. Positions 1 to 96 are padding. Positions 97 onward hold six-bit groups for output 15 first, down to output 0 last.
- R5: In the group for output k, the first bit is the enable. The next five bits are the input index, most significant bit first. An enabled output drives exactly bit `k*32+index` of `route_sel` high within its 32-bit slice.
- R6: An output whose enable bit is 0 has `out_en[k]` = 0 and an all-zero 32-bit `route_sel` slice, whatever its index bits hold.
- R7: `test_mode` is 1 exactly when at least one latched padding bit is 1.
- R8: The live configuration copies the shift register while `update_n` and `cs_n` are both low, and holds its value while `update_n` is high.
- R9: While `rst_n` is low, with or without a clock edge, the following are all 0: the shift register (and so `sdo`), `out_en`, `route_sel`, `clamp_en` and `test_mode`.
- R10: While the latch is open during shifting, the live configuration follows every intermediate state of the shift register. `clamp_en` then equals `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in |
| update_n | input | 1 | Second-rank latch enable, transparent when low |
| sdo | output | 1 | Serial data out, far end of the shift register |
| clamp_en | output | 1 | Global clamp enable from the live word |
| test_mode | output | 1 | High when any live padding bit is set |
| out_en | output | 16 | Per-output enable |
| route_sel | output | 512 | Per-output one-hot input select, output k in bits k*32+31..k*32 |

## Verification
Shifting and second-rank transfer can fall in the same cycle: when `update_n` is held low while frames are clocked in, the live word changes on every shift edge. The bench provokes this by streaming a whole frame with the latch open. It compares `clamp_en` against `sdo` while the latch is still open, and checks that the final decoded routes match the frame. A checker property requires the same equality at every open-latch edge. The opposite overlap is also exercised: `update_n` held low with `cs_n` high while `sdi` toggles. Here the port must freeze both ranks, and this is judged against the previously loaded configuration and the pending `sdo` bit.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int NIN_DEF  = 32;
  localparam int NOUT_DEF = 16;
  localparam int PAD_DEF  = 96;

  function automatic int frame_bits(input int nin, input int nout, input int pad);
    return 1 + pad + nout * ($clog2(nin) + 1);
  endfunction
endpackage

// File: rtl/xpt_shift_chain.sv
module xpt_shift_chain #(
  parameter int W = 193
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sdi,
  output logic [W-1:0] word,
  output logic         sdo,
  output logic         pre_tail
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (!cs_n) sr <= {sr[W-2:0], sdi};
  end

  assign word     = sr;
  assign sdo      = sr[W-1];
  assign pre_tail = sr[W-2];
endmodule

// File: rtl/xpt_live_latch.sv
module xpt_live_latch #(
  parameter int W = 193
) (
  input  logic         rst_n,
  input  logic         open_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)       q <= '0;
    else if (open_en) q <= d;
  end
endmodule

// File: rtl/xpt_route_decode.sv
module xpt_route_decode #(
  parameter int NIN  = 32,
  parameter int NOUT = 16,
  parameter int PADW = 96,
  localparam int IDXW = $clog2(NIN),
  localparam int GRPW = IDXW + 1,
  localparam int W    = 1 + PADW + NOUT * GRPW
) (
  input  logic [W-1:0]         live,
  output logic                 clamp_en,
  output logic                 test_mode,
  output logic [NOUT-1:0]      out_en,
  output logic [NOUT*NIN-1:0]  route_sel
);
  function automatic logic [NIN-1:0] route_vec(input logic en, input logic [IDXW-1:0] ix);
    logic [NIN-1:0] v;
    v = '0;
    if (en) v[ix] = 1'b1;
    return v;
  endfunction

  assign clamp_en  = live[W-1];
  assign test_mode = |live[W-2 -: PADW];

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic            en;
    logic [IDXW-1:0] ix;
    assign en = live[k*GRPW + IDXW];
    assign ix = live[k*GRPW +: IDXW];
    assign out_en[k]               = en;
    assign route_sel[k*NIN +: NIN] = route_vec(en, ix);
  end
endmodule

// File: rtl/xpt_cfg_port.sv
module xpt_cfg_port #(
  parameter int NIN  = xpt_cfg_pkg::NIN_DEF,
  parameter int NOUT = xpt_cfg_pkg::NOUT_DEF,
  parameter int PADW = xpt_cfg_pkg::PAD_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sdi,
  input  logic                update_n,
  output logic                sdo,
  output logic                clamp_en,
  output logic                test_mode,
  output logic [NOUT-1:0]     out_en,
  output logic [NOUT*NIN-1:0] route_sel
);
  localparam int FRAMEW = xpt_cfg_pkg::frame_bits(NIN, NOUT, PADW);

  logic [FRAMEW-1:0] shadow_word;
  logic [FRAMEW-1:0] live_word;
  logic              pre_tail;
  logic              latch_open;

  assign latch_open = !update_n && !cs_n;

  xpt_shift_chain #(.W(FRAMEW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .word(shadow_word), .sdo(sdo), .pre_tail(pre_tail)
  );

  xpt_live_latch #(.W(FRAMEW)) u_live (
    .rst_n(rst_n), .open_en(latch_open), .d(shadow_word), .q(live_word)
  );

  xpt_route_decode #(.NIN(NIN), .NOUT(NOUT), .PADW(PADW)) u_dec (
    .live(live_word), .clamp_en(clamp_en), .test_mode(test_mode),
    .out_en(out_en), .route_sel(route_sel)
  );
endmodule

// File: rtl/xpt_cfg_port_chk.sv
module xpt_cfg_port_chk #(
  parameter int NIN  = 32,
  parameter int NOUT = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                update_n,
  input logic                sdo,
  input logic                pre_tail,
  input logic                clamp_en,
  input logic                test_mode,
  input logic [NOUT-1:0]     out_en,
  input logic [NOUT*NIN-1:0] route_sel
);
  // R3: deselected port keeps its serial state
  a_r3_frozen_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sdo));

  // R2: each selected edge advances the chain by one position
  a_r2_shift_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> sdo == $past(pre_tail));

  // R10: open latch mirrors the shift register
  a_r10_transparent_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_n && !cs_n) |-> clamp_en == sdo);

  // R9: reset keeps everything quiet
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (out_en == '0 && sdo == 1'b0 && !test_mode && !clamp_en));

  for (genvar k = 0; k < NOUT; k++) begin : g_chk
    // R6: disabled output routes nothing
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[k] |-> route_sel[k*NIN +: NIN] == '0);
    // R5: enabled output routes exactly one input
    a_r5_single_route: assert property (@(posedge clk) disable iff (!rst_n)
      out_en[k] |-> $countones(route_sel[k*NIN +: NIN]) == 1);
  end
endmodule

bind xpt_cfg_port xpt_cfg_port_chk #(.NIN(NIN), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .update_n(update_n), .sdo(sdo),
  .pre_tail(pre_tail), .clamp_en(clamp_en), .test_mode(test_mode),
  .out_en(out_en), .route_sel(route_sel)
);

// File: tb/xpt_cfg_port_bench.sv
module xpt_cfg_port_bench;
  localparam int FW = 193;

  logic clk = 1'b0;
  logic rst_n, cs_n, sdi, update_n;
  logic link, b_sdo;
  logic a_clamp, a_test, b_clamp, b_test;
  logic [15:0]  a_en, b_en;
  logic [511:0] a_sel, b_sel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xpt_cfg_port u_xpt_cfg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .update_n(update_n),
    .sdo(link), .clamp_en(a_clamp), .test_mode(a_test), .out_en(a_en), .route_sel(a_sel)
  );
  xpt_cfg_port u_xpt_cfg_port_b (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(link), .update_n(update_n),
    .sdo(b_sdo), .clamp_en(b_clamp), .test_mode(b_test), .out_en(b_en), .route_sel(b_sel)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // frame bit at stream position p lives at index FW-1-p
  function automatic logic [FW-1:0] mk(input logic c, input logic [95:0] pad,
                                       input logic [15:0] en, input logic [79:0] ix);
    logic [FW-1:0] f;
    f = '0;
    f[FW-1] = c;
    for (int p = 0; p < 96; p++) f[FW-2-p] = pad[95-p];
    for (int k = 0; k < 16; k++) begin
      int base;
      base = 97 + 6 * (15 - k);
      f[FW-1-base] = en[k];
      for (int j = 0; j < 5; j++) f[FW-1-(base+1+j)] = ix[k*5 + 4 - j];
    end
    return f;
  endfunction

  function automatic logic [FW-1:0] rnd_frame();
    logic [15:0] en;
    logic [79:0] ix;
    for (int k = 0; k < 16; k++) begin
      en[k] = ($urandom % 4) != 0;
      ix[k*5 +: 5] = 5'($urandom);
    end
    return mk(1'($urandom), 96'd0, en, ix);
  endfunction

  task automatic check_cfg(input int dev, input logic [FW-1:0] f, input string tag);
    logic [15:0]  e_en;
    logic [511:0] e_sel;
    logic         e_test;
    e_sel = '0; e_test = 1'b0;
    for (int p = 1; p <= 96; p++) if (f[FW-1-p]) e_test = 1'b1;
    for (int k = 0; k < 16; k++) begin
      int base;
      int idx;
      base = 97 + 6 * (15 - k);
      e_en[k] = f[FW-1-base];
      idx = 0;
      for (int j = 0; j < 5; j++) idx = idx * 2 + int'(f[FW-1-(base+1+j)]);
      for (int i = 0; i < 32; i++) e_sel[k*32+i] = e_en[k] && (i == idx);
    end
    if (dev == 0) begin
      chk({tag, " clamp"}, 512'(a_clamp), 512'(f[FW-1]));
      chk({tag, " test_mode R7"}, 512'(a_test), 512'(e_test));
      chk({tag, " out_en R6"}, 512'(a_en), 512'(e_en));
      chk({tag, " route_sel R5"}, a_sel, e_sel);
    end else begin
      chk({tag, " dev1 clamp"}, 512'(b_clamp), 512'(f[FW-1]));
      chk({tag, " dev1 test_mode"}, 512'(b_test), 512'(e_test));
      chk({tag, " dev1 out_en"}, 512'(b_en), 512'(e_en));
      chk({tag, " dev1 route_sel"}, b_sel, e_sel);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    cs_n = 1'b0;
    sdi  = b;
  endtask

  task automatic shift_frame(input logic [FW-1:0] f);
    for (int p = 0; p < FW; p++) shift_bit(f[FW-1-p]);
  endtask

  task automatic end_shift();
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic pulse_update();
    @(negedge clk);
    cs_n = 1'b0; update_n = 1'b0;
    #2;
    update_n = 1'b1; cs_n = 1'b1;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, fb, fc, fd, fe, ff, fg, fh;
    logic [15:0] en;
    logic [79:0] ix;
    logic [95:0] pad;
    void'($urandom(32'd4711));
    rst_n = 1'b0; cs_n = 1'b1; sdi = 1'b0; update_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check_cfg(0, '0, "R9 reset");
    chk("R9 sdo", 512'(link), 512'd0);
    rst_n = 1'b1;

    // R2 two-port chain, farthest frame first; R8 hold before update
    fa = rnd_frame(); fb = rnd_frame();
    shift_frame(fb); shift_frame(fa); end_shift();
    check_cfg(0, '0, "R8 hold");
    pulse_update();
    check_cfg(0, fa, "R2/R4");
    check_cfg(1, fb, "R2");

    // R1 frame length at sdo
    fc = rnd_frame();
    shift_frame(fc); end_shift();
    chk("R1 first bit at sdo", 512'(link), 512'(fc[FW-1]));
    shift_bit(1'b1); end_shift();
    chk("R1 second bit at sdo", 512'(link), 512'(fc[FW-2]));

    // R3 deselected with latch strobe low
    fd = rnd_frame();
    shift_frame(fd); end_shift();
    update_n = 1'b0;
    repeat (40) begin
      @(negedge clk);
      sdi = 1'($urandom);
    end
    @(negedge clk);
    check_cfg(0, fa, "R3 frozen");
    chk("R3 sdo frozen", 512'(link), 512'(fd[FW-1]));
    update_n = 1'b1;
    pulse_update();
    check_cfg(0, fd, "R8 transfer");

    // R5 extremes of the index
    en = '1;
    for (int k = 0; k < 16; k++) ix[k*5 +: 5] = (k % 2) ? 5'd31 : 5'd0;
    fe = mk(1'b0, 96'd0, en, ix);
    shift_frame(fe); end_shift(); pulse_update();
    check_cfg(0, fe, "R5 extremes");

    // R6 disabled outputs with nonzero index
    for (int k = 0; k < 16; k++) ix[k*5 +: 5] = 5'd31;
    ff = mk(1'b1, 96'd0, 16'h0000, ix);
    shift_frame(ff); end_shift(); pulse_update();
    check_cfg(0, ff, "R6 disabled");

    // R7 single padding bit
    pad = '0;
    pad[$urandom % 96] = 1'b1;
    fg = mk(1'b0, pad, 16'h5a5a, ix);
    shift_frame(fg); end_shift(); pulse_update();
    check_cfg(0, fg, "R7 pad set");
    chk("R7 flag raised", 512'(a_test), 512'd1);

    // R10 latch open while shifting
    fh = rnd_frame();
    @(negedge clk); update_n = 1'b0;
    shift_frame(fh);
    @(negedge clk);
    chk("R10 clamp follows sdo", 512'(a_clamp), 512'(link));
    cs_n = 1'b1; update_n = 1'b1;
    #1;
    check_cfg(0, fh, "R10 final");

    // R9 asynchronous reset between edges
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async out_en", 512'(a_en), 512'd0);
    chk("R9 async route_sel", a_sel, 512'd0);
    chk("R9 async sdo", 512'(link), 512'd0);
    chk("R9 async clamp", 512'(a_clamp), 512'd0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule